// File: doc/BRIEF.md
# SDRAM Bank Command Timing Guard

This block sits beside an SDRAM command bus and watches the commands that another agent issues, one per clock. It does not drive the memory. It keeps its own picture of the four banks, each either open or idle. For every timing rule that a command depends on, it keeps a counter of clocks since the command that started that rule. When a command arrives too soon, or arrives while its bank is in a state that forbids it, the block raises a one-clock error pulse. The pulse carries a reason code and the bank field of the offending command.

The timing distances in clocks come in on ports, so the same guard fits any clock rate. These are activate-to-column, activate-to-precharge, same-bank and cross-bank activate spacing, and precharge time. The programmed CAS latency and burst length also come in on ports, as mode-register codes. The guard's bank model follows every decoded command, including one that it flags. The guard stores no data.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Commands are decoded from {csN,rasN,casN,weN}: activate 0011, read 0101, write 0100, burst stop 0110, precharge 0010, refresh 0001, mode set 0000; csN high or 0111 is no command. The bank is ba (0..3) and maps to bit ba of bankOpen. An activate opens its bank. A precharge with a10 low closes its bank. A precharge with a10 high closes all banks. bankOpen is 0 after reset.
- R2: Each of these raises code 1 (illegal state): a read or write to an idle bank; an activate to an open bank; a mode set or refresh while any bank is open.
- R3: A read or write fewer than tRcd clocks after the activate of its bank raises code 2.
- R4: A precharge that closes a bank fewer than tRas clocks after that bank's activate raises code 3. For an all-bank precharge, any open bank that is still too young counts.
- R5: An activate fewer than tRc clocks after the previous activate of the same bank raises code 4. An activate fewer than tRp clocks after the precharge of its bank raises code 6, and code 6 takes priority over code 4.
- R6: An activate fewer than tRrd clocks after an activate of any bank raises code 5.
- R7: A write of burst length BL issued at cycle W allows a precharge of its bank from W+BL+1 on. An earlier precharge raises code 7. In full-page mode (blCode bit 2 set) the write stays pending until a burst stop at cycle S, and precharge is then allowed from S+1.
- R8: A read or write with a10 high at cycle C closes its bank at once. A read or write to that bank before C+BL raises code 8. An activate of that bank before C+BL+tRp raises code 6.
- R9: A read or write with a10 high in full-page mode raises code 9.
- R10: A single-bank precharge issued inside the burst of a read, fewer than BL clocks after it, raises code 10 if its bank differs from the read's bank. The same bank is legal.
- R11: A read while clCode is neither 010 (latency 2) nor 011 (latency 3) raises code 11. A write is not affected.
- R12: Any command within 2 clocks of a mode set raises code 12.
- R13: Results are registered. errPulse, errCode and errBank (the command's ba) are valid in the cycle after the command and last one cycle. errCode is 0 when errPulse is low. When several rules fail, the code is chosen in this priority order: 12, 9, 11, 8, 1, 6, 4, 5, 2, 3, 7, 10. blCode 0..3 give BL 1, 2, 4, 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select of the watched bus, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank field |
| a10 | input | 1 | Auto-precharge / all-bank flag |
| clCode | input | 3 | Programmed CAS latency code |
| blCode | input | 3 | Programmed burst length code |
| tRcd | input | CNT_W | Activate to column command, clocks |
| tRas | input | CNT_W | Activate to precharge, clocks |
| tRc | input | CNT_W | Activate to activate, same bank, clocks |
| tRrd | input | CNT_W | Activate to activate, any bank, clocks |
| tRp | input | CNT_W | Precharge to activate, clocks |
| bankOpen | output | 4 | Open flag for each bank |
| errPulse | output | 1 | One-cycle violation pulse |
| errCode | output | 4 | Reason code of the violation |
| errBank | output | 2 | Bank field of the flagged command |

## Verification
Every result appears one clock after the command's sampling edge. The bank flags and the error outputs are both single registers, so the bench drives each command at a falling edge and reads the outputs at the next falling edge, before the following command is sampled. Each rule is probed by placing the dependent command at a known clock distance from the command that started the rule. One case falls one clock inside the limit and is expected to fail. A second case, after a fresh reset, sits exactly on the limit and is expected to pass. Per-bank counters start at the starting command's edge, so a command k clocks later sees the distance k directly.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W = 2;

  typedef enum logic [3:0] {
    ERR_NONE   = 4'd0,
    ERR_STATE  = 4'd1,
    ERR_TRCD   = 4'd2,
    ERR_TRAS   = 4'd3,
    ERR_TRC    = 4'd4,
    ERR_TRRD   = 4'd5,
    ERR_TRP    = 4'd6,
    ERR_TRDL   = 4'd7,
    ERR_APBUSY = 4'd8,
    ERR_APFULL = 4'd9,
    ERR_RDINT  = 4'd10,
    ERR_BADCL  = 4'd11,
    ERR_MRD    = 4'd12
  } errCode_e;

  // strobes from the rule logic to the counter datapath
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic bst;
    logic mrs;
    logic autoPre;
    logic [BANK_W-1:0] bank;
  } strobe_t;

  // busy/state view returned by the datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] open;
    logic [NUM_BANKS-1:0] rcdBusy;
    logic [NUM_BANKS-1:0] rasBusy;
    logic [NUM_BANKS-1:0] rcBusy;
    logic [NUM_BANKS-1:0] rpBusy;
    logic [NUM_BANKS-1:0] wrBusy;
    logic [NUM_BANKS-1:0] apBusy;
    logic rrdBusy;
    logic rdBusy;
    logic mrdBusy;
    logic [BANK_W-1:0] rdBank;
  } status_t;
endpackage

// File: rtl/guard_timers.sv
module guard_timers
  import sdram_guard_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [CNT_W+1:0]     burstLen,
  input  logic                 fullPage,
  input  logic [CNT_W-1:0]     tRcd,
  input  logic [CNT_W-1:0]     tRas,
  input  logic [CNT_W-1:0]     tRc,
  input  logic [CNT_W-1:0]     tRrd,
  input  logic [CNT_W-1:0]     tRp,
  output status_t              st
);
  localparam int CW = CNT_W + 2;

  // a distance of d clocks: the counter reaches zero exactly d clocks later
  function automatic logic [CW-1:0] loadFor(input logic [CW-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  function automatic logic [CW-1:0] stepDown(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  logic [CW-1:0] rrdCnt, mrdCnt, rdCnt;
  logic          rdHold;
  logic [BANK_W-1:0] rdBankQ, lastWrBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrdCnt <= '0;
      mrdCnt <= '0;
      rdCnt <= '0;
      rdHold <= 1'b0;
      rdBankQ <= '0;
      lastWrBank <= '0;
    end else begin
      rrdCnt <= stb.act ? loadFor(CW'(tRrd)) : stepDown(rrdCnt);
      mrdCnt <= stb.mrs ? loadFor(CW'(2)) : stepDown(mrdCnt);
      if (stb.rd) begin
        rdCnt <= loadFor(burstLen);
        rdHold <= fullPage;
        rdBankQ <= stb.bank;
      end else if (stb.wr || stb.bst) begin
        rdCnt <= '0;
        rdHold <= 1'b0;
      end else begin
        rdCnt <= stepDown(rdCnt);
      end
      if (stb.wr) lastWrBank <= stb.bank;
    end
  end

  logic [NUM_BANKS-1:0] openV, rcdV, rasV, rcV, rpV, wrV, apV;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic hit, colAp, closing;
    logic openQ, wrHold;
    logic [CW-1:0] rcdCnt, rasCnt, rcCnt, rpCnt, wrCnt, apCnt;

    assign hit = (stb.bank == BANK_W'(b));
    assign colAp = (stb.rd || stb.wr) && stb.autoPre && hit;
    assign closing = stb.preAll || (stb.pre && hit);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ <= 1'b0;
        wrHold <= 1'b0;
        rcdCnt <= '0;
        rasCnt <= '0;
        rcCnt <= '0;
        rpCnt <= '0;
        wrCnt <= '0;
        apCnt <= '0;
      end else begin
        if (stb.act && hit) openQ <= 1'b1;
        else if (colAp || closing) openQ <= 1'b0;

        if (stb.act && hit) begin
          rcdCnt <= loadFor(CW'(tRcd));
          rasCnt <= loadFor(CW'(tRas));
          rcCnt <= loadFor(CW'(tRc));
        end else begin
          rcdCnt <= stepDown(rcdCnt);
          rasCnt <= stepDown(rasCnt);
          rcCnt <= stepDown(rcCnt);
        end

        if (colAp) rpCnt <= loadFor(burstLen + CW'(tRp));
        else if (closing && openQ) rpCnt <= loadFor(CW'(tRp));
        else rpCnt <= stepDown(rpCnt);

        apCnt <= colAp ? loadFor(burstLen) : stepDown(apCnt);

        if (stb.wr && hit) begin
          wrCnt <= loadFor(burstLen + CW'(1));
          wrHold <= fullPage;
        end else if (stb.bst && lastWrBank == BANK_W'(b)) begin
          wrCnt <= '0;
          wrHold <= 1'b0;
        end else begin
          wrCnt <= stepDown(wrCnt);
        end
      end
    end

    assign openV[b] = openQ;
    assign rcdV[b] = (rcdCnt != '0);
    assign rasV[b] = (rasCnt != '0);
    assign rcV[b] = (rcCnt != '0);
    assign rpV[b] = (rpCnt != '0);
    assign wrV[b] = wrHold || (wrCnt != '0);
    assign apV[b] = (apCnt != '0);
  end

  assign st = '{open: openV, rcdBusy: rcdV, rasBusy: rasV, rcBusy: rcV,
                rpBusy: rpV, wrBusy: wrV, apBusy: apV,
                rrdBusy: (rrdCnt != '0), rdBusy: rdHold || (rdCnt != '0),
                mrdBusy: (mrdCnt != '0), rdBank: rdBankQ};
endmodule

// File: rtl/guard_rules.sv
module guard_rules
  import sdram_guard_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               rasN,
  input  logic               casN,
  input  logic               weN,
  input  logic [BANK_W-1:0]  ba,
  input  logic               a10,
  input  logic [2:0]         clCode,
  input  logic [2:0]         blCode,
  input  status_t            st,
  output strobe_t            stb,
  output logic [CNT_W+1:0]   burstLen,
  output logic               fullPage,
  output logic               errPulse,
  output logic [3:0]         errCode,
  output logic [BANK_W-1:0]  errBank
);
  logic sel, isAct, isRd, isWr, isBst, isPre, isPreAll, isRef, isMrs, isAny;
  logic isCol, clOk;
  errCode_e errNext;

  assign sel = !csN;
  assign isAct = sel && {rasN, casN, weN} == 3'b011;
  assign isRd = sel && {rasN, casN, weN} == 3'b101;
  assign isWr = sel && {rasN, casN, weN} == 3'b100;
  assign isBst = sel && {rasN, casN, weN} == 3'b110;
  assign isPre = sel && {rasN, casN, weN} == 3'b010 && !a10;
  assign isPreAll = sel && {rasN, casN, weN} == 3'b010 && a10;
  assign isRef = sel && {rasN, casN, weN} == 3'b001;
  assign isMrs = sel && {rasN, casN, weN} == 3'b000;
  assign isAny = sel && {rasN, casN, weN} != 3'b111;
  assign isCol = isRd || isWr;

  assign clOk = (clCode == 3'b010) || (clCode == 3'b011);
  assign fullPage = blCode[2];
  assign burstLen = (CNT_W+2)'(1) << blCode[1:0];

  assign stb = '{act: isAct, rd: isRd, wr: isWr, pre: isPre, preAll: isPreAll,
                 bst: isBst, mrs: isMrs, autoPre: a10, bank: ba};

  always_comb begin
    errNext = ERR_NONE;
    if (isAny && st.mrdBusy) errNext = ERR_MRD;
    else if (isCol && a10 && fullPage) errNext = ERR_APFULL;
    else if (isRd && !clOk) errNext = ERR_BADCL;
    else if (isCol && st.apBusy[ba]) errNext = ERR_APBUSY;
    else if ((isCol && !st.open[ba]) || (isAct && st.open[ba]) ||
             ((isMrs || isRef) && |st.open)) errNext = ERR_STATE;
    else if (isAct && st.rpBusy[ba]) errNext = ERR_TRP;
    else if (isAct && st.rcBusy[ba]) errNext = ERR_TRC;
    else if (isAct && st.rrdBusy) errNext = ERR_TRRD;
    else if (isCol && st.rcdBusy[ba]) errNext = ERR_TRCD;
    else if ((isPre && st.open[ba] && st.rasBusy[ba]) ||
             (isPreAll && |(st.open & st.rasBusy))) errNext = ERR_TRAS;
    else if ((isPre && st.wrBusy[ba]) || (isPreAll && |st.wrBusy)) errNext = ERR_TRDL;
    else if (isPre && st.rdBusy && st.rdBank != ba) errNext = ERR_RDINT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse <= 1'b0;
      errCode <= ERR_NONE;
      errBank <= '0;
    end else begin
      errPulse <= (errNext != ERR_NONE);
      errCode <= errNext;
      errBank <= ba;
    end
  end
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        ba,
  input  logic              a10,
  input  logic [2:0]        clCode,
  input  logic [2:0]        blCode,
  input  logic [CNT_W-1:0]  tRcd,
  input  logic [CNT_W-1:0]  tRas,
  input  logic [CNT_W-1:0]  tRc,
  input  logic [CNT_W-1:0]  tRrd,
  input  logic [CNT_W-1:0]  tRp,
  output logic [3:0]        bankOpen,
  output logic              errPulse,
  output logic [3:0]        errCode,
  output logic [1:0]        errBank
);
  strobe_t stb;
  status_t st;
  logic [CNT_W+1:0] burstLen;
  logic fullPage;

  guard_rules #(.CNT_W(CNT_W)) uRules (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .a10(a10), .clCode(clCode), .blCode(blCode), .st(st),
    .stb(stb), .burstLen(burstLen), .fullPage(fullPage),
    .errPulse(errPulse), .errCode(errCode), .errBank(errBank)
  );

  guard_timers #(.CNT_W(CNT_W)) uTimers (
    .clk(clk), .rstN(rstN), .stb(stb), .burstLen(burstLen), .fullPage(fullPage),
    .tRcd(tRcd), .tRas(tRas), .tRc(tRc), .tRrd(tRrd), .tRp(tRp), .st(st)
  );

  assign bankOpen = st.open;
endmodule

// File: rtl/sdram_cmd_guard_props.sv
module sdram_cmd_guard_props #(
  parameter int CNT_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [1:0]        ba,
  input logic              a10,
  input logic [2:0]        blCode,
  input logic [CNT_W-1:0]  tRcd,
  input logic [3:0]        bankOpen,
  input logic              errPulse,
  input logic [3:0]        errCode
);
  logic pAct, pCol, pPreAll, pMrs, pAny;
  assign pAct = !csN && {rasN, casN, weN} == 3'b011;
  assign pCol = !csN && ({rasN, casN, weN} == 3'b101 || {rasN, casN, weN} == 3'b100);
  assign pPreAll = !csN && {rasN, casN, weN} == 3'b010 && a10;
  assign pMrs = !csN && {rasN, casN, weN} == 3'b000;
  assign pAny = !csN && {rasN, casN, weN} != 3'b111;

  assert_code_with_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    errPulse == (errCode != 4'd0));

  assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rstN)
    pAct |=> bankOpen[$past(ba)]);

  assert_pre_all_closes_R1: assert property (@(posedge clk) disable iff (!rstN)
    pPreAll |=> bankOpen == 4'b0000);

  assert_idle_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pCol && !bankOpen[ba]) |=> errPulse);

  assert_double_act_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pAct && bankOpen[ba]) |=> errPulse);

  assert_rcd_early_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pAct) && pCol && ba == $past(ba) && tRcd > 1) |=> errPulse);

  assert_ap_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pCol && a10 && blCode[2]) |=> errPulse);

  assert_mrs_gap_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pMrs) && pAny) |=> errPulse);
endmodule

bind sdram_cmd_guard sdram_cmd_guard_props #(.CNT_W(CNT_W)) uProps (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .ba(ba), .a10(a10), .blCode(blCode), .tRcd(tRcd), .bankOpen(bankOpen),
  .errPulse(errPulse), .errCode(errCode)
);

// File: tb/sdram_cmd_guard_test.sv
module sdram_cmd_guard_test;
  localparam int CNT_W = 6;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         BST = 4'b0110, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [2:0] clCode = 3'b010, blCode = 3'b010;
  logic [CNT_W-1:0] tRcd = 3, tRas = 6, tRc = 9, tRrd = 2, tRp = 3;
  logic [3:0] bankOpen, errCode;
  logic errPulse;
  logic [1:0] errBank;

  int nChk = 0, nBad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_guard #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .a10(a10), .clCode(clCode), .blCode(blCode),
    .tRcd(tRcd), .tRas(tRas), .tRc(tRc), .tRrd(tRrd), .tRp(tRp),
    .bankOpen(bankOpen), .errPulse(errPulse), .errCode(errCode), .errBank(errBank)
  );

  task automatic compare(string tag, int actual, int expected);
    nChk++;
    if (actual != expected) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  task automatic doReset(input logic [2:0] bl = 3'b010, input logic [CNT_W-1:0] rc = 9);
    @(negedge clk);
    rstN = 1'b0;
    {csN, rasN, casN, weN} = NOP;
    blCode = bl;
    tRc = rc;
    clCode = 3'b010;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
  endtask

  // drive a command for one clock; outputs are read at the following falling edge
  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic a);
    {csN, rasN, casN, weN} = c;
    ba = b;
    a10 = a;
    @(posedge clk);
    @(negedge clk);
    {csN, rasN, casN, weN} = NOP;
    a10 = 1'b0;
    cyc++;
  endtask

  task automatic at(input int k, input logic [3:0] c, input logic [1:0] b, input logic a);
    while (cyc < k) issue(NOP, 2'd0, 1'b0);
    issue(c, b, a);
  endtask

  task automatic expectErr(string tag, int code);
    compare({tag, " pulse"}, int'(errPulse), int'(code != 0));
    compare({tag, " code"}, int'(errCode), code);
  endtask

  task automatic testReset();
    doReset();
    compare("R1 bankOpen after reset", int'(bankOpen), 0);
    expectErr("R13 idle after reset", 0);
  endtask

  task automatic testRcd();
    doReset();
    at(0, ACT, 2'd0, 1'b0);
    compare("R1 activate opens bank0", int'(bankOpen), 1);
    at(1, RD, 2'd0, 1'b0);
    expectErr("R3 read one clock after activate", 2);
    compare("R13 errBank", int'(errBank), 0);
    at(2, NOP, 2'd0, 1'b0);
    expectErr("R13 pulse lasts one cycle", 0);
    at(3, RD, 2'd0, 1'b0);
    expectErr("R3 read at tRcd", 0);
  endtask

  task automatic testState();
    doReset();
    at(0, RD, 2'd2, 1'b0);
    expectErr("R2 read idle bank", 1);
    compare("R13 errBank bank2", int'(errBank), 2);
    at(1, WR, 2'd1, 1'b0);
    expectErr("R2 write idle bank", 1);
    at(2, ACT, 2'd1, 1'b0);
    at(4, ACT, 2'd1, 1'b0);
    expectErr("R2 activate open bank before tRc", 1);
    compare("R1 only bank1 open", int'(bankOpen), 2);
  endtask

  task automatic testRas();
    doReset();
    at(0, ACT, 2'd0, 1'b0);
    at(2, ACT, 2'd2, 1'b0);
    at(3, PRE, 2'd2, 1'b0);
    expectErr("R4 precharge before tRas", 3);
    compare("R13 errBank for tRas", int'(errBank), 2);
    at(6, PRE, 2'd0, 1'b1);
    expectErr("R4 all-bank precharge at tRas", 0);
    compare("R1 all-bank precharge closes", int'(bankOpen), 0);
  endtask

  task automatic testRcRp();
    doReset(3'b010, 11);
    at(0, ACT, 2'd0, 1'b0);
    at(6, PRE, 2'd0, 1'b0);
    at(8, ACT, 2'd0, 1'b0);
    expectErr("R5 activate before tRp", 6);
    doReset(3'b010, 11);
    at(0, ACT, 2'd0, 1'b0);
    at(6, PRE, 2'd0, 1'b0);
    at(9, ACT, 2'd0, 1'b0);
    expectErr("R5 activate before tRc", 4);
    doReset(3'b010, 9);
    at(0, ACT, 2'd0, 1'b0);
    at(6, PRE, 2'd0, 1'b0);
    at(9, ACT, 2'd0, 1'b0);
    expectErr("R5 activate at tRc and tRp", 0);
  endtask

  task automatic testRrd();
    doReset();
    at(0, ACT, 2'd0, 1'b0);
    at(1, ACT, 2'd1, 1'b0);
    expectErr("R6 activate before tRrd", 5);
    at(3, ACT, 2'd2, 1'b0);
    expectErr("R6 activate at tRrd", 0);
    compare("R1 banks 0..2 open", int'(bankOpen), 7);
  endtask

  task automatic testWriteRecovery();
    doReset();
    at(0, ACT, 2'd0, 1'b0);
    at(3, WR, 2'd0, 1'b0);
    at(7, PRE, 2'd0, 1'b0);
    expectErr("R7 precharge inside write recovery", 7);
    doReset();
    at(0, ACT, 2'd0, 1'b0);
    at(3, WR, 2'd0, 1'b0);
    at(8, PRE, 2'd0, 1'b0);
    expectErr("R7 precharge at BL+1", 0);
    doReset(3'b111);
    at(0, ACT, 2'd0, 1'b0);
    at(3, WR, 2'd0, 1'b0);
    at(9, PRE, 2'd0, 1'b0);
    expectErr("R7 full-page write still pending", 7);
    doReset(3'b111);
    at(0, ACT, 2'd0, 1'b0);
    at(3, WR, 2'd0, 1'b0);
    at(10, BST, 2'd0, 1'b0);
    at(11, PRE, 2'd0, 1'b0);
    expectErr("R7 precharge one clock after burst stop", 0);
  endtask

  task automatic testAutoPre();
    doReset();
    at(0, ACT, 2'd1, 1'b0);
    at(3, RD, 2'd1, 1'b1);
    expectErr("R8 read with auto precharge", 0);
    compare("R8 bank closes at command", int'(bankOpen), 0);
    at(5, RD, 2'd1, 1'b0);
    expectErr("R8 access during auto-precharge burst", 8);
    at(9, ACT, 2'd1, 1'b0);
    expectErr("R8 activate before BL+tRp", 6);
    doReset();
    at(0, ACT, 2'd1, 1'b0);
    at(3, WR, 2'd1, 1'b1);
    at(10, ACT, 2'd1, 1'b0);
    expectErr("R8 activate at BL+tRp", 0);
    compare("R8 bank1 reopened", int'(bankOpen), 2);
  endtask

  task automatic testApFull();
    doReset(3'b111);
    at(0, ACT, 2'd0, 1'b0);
    at(3, WR, 2'd0, 1'b1);
    expectErr("R9 auto precharge in full page", 9);
  endtask

  task automatic testReadInterrupt();
    doReset();
    at(0, ACT, 2'd1, 1'b0);
    at(2, ACT, 2'd0, 1'b0);
    at(5, RD, 2'd0, 1'b0);
    at(6, PRE, 2'd1, 1'b0);
    expectErr("R10 precharge other bank during read", 10);
    compare("R13 errBank for interrupt", int'(errBank), 1);
    at(8, PRE, 2'd0, 1'b0);
    expectErr("R10 precharge same bank during read", 0);
  endtask

  task automatic testCasLatency();
    doReset();
    clCode = 3'b100;
    at(0, ACT, 2'd0, 1'b0);
    at(3, RD, 2'd0, 1'b0);
    expectErr("R11 read with reserved latency", 11);
    at(4, WR, 2'd0, 1'b0);
    expectErr("R11 write ignores latency code", 0);
    clCode = 3'b011;
    at(5, RD, 2'd0, 1'b0);
    expectErr("R11 read with latency 3", 0);
  endtask

  task automatic testModeSet();
    doReset();
    at(0, MRS, 2'd0, 1'b0);
    expectErr("R12 mode set with banks idle", 0);
    at(1, ACT, 2'd0, 1'b0);
    expectErr("R12 command one clock after mode set", 12);
    at(2, REF, 2'd0, 1'b0);
    expectErr("R2 refresh with open bank", 1);
    at(3, MRS, 2'd0, 1'b0);
    expectErr("R2 mode set with open bank", 1);
    doReset();
    at(0, MRS, 2'd0, 1'b0);
    at(2, ACT, 2'd0, 1'b0);
    expectErr("R12 command two clocks after mode set", 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog R13 actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    testReset();
    testRcd();
    testState();
    testRas();
    testRcRp();
    testRrd();
    testWriteRecovery();
    testAutoPre();
    testApFull();
    testReadInterrupt();
    testCasLatency();
    testModeSet();
    report();
    $finish;
  end
endmodule